// File: doc/BRIEF.md
# Real-Time Clock Hours Counter with 12/24-Hour Formats

This block keeps the hour of day for a real-time clock as a packed BCD byte. A one-cycle tick from the minutes stage advances it by one hour. A level input selects the display format. In 24-hour format the count runs from 00 to 23. In 12-hour format it runs 12, 01 … 11, and the top bit of the byte marks the afternoon.

When the format input changes, the stored hour is rewritten in the new format. The time of day does not change, so software does not have to reload it. The block does not convert any alarm hour values; software must rewrite those itself. A write port loads a new hour directly. A one-cycle day-carry pulse tells the date stage that midnight has passed.

Every output is registered. All inputs are sampled on the rising clock edge, and the result is visible right after that edge.

Top module: `hour_keeper`

## Requirements
- R1: In the first cycle after a synchronous reset, `hours_q` is 0x00 in 24-hour format and `day_carry` is 0.
- R2: In 24-hour format (`fmt_12h`=0), each `hour_tick` advances `hours_q` by one through the BCD values 0x00 to 0x23. The new value appears one cycle after the tick.
- R3: In 24-hour format, a tick at 0x23 gives 0x00 and raises `day_carry` for exactly one cycle. No other tick raises it.
- R4: In 12-hour format, bits 5:0 count 12, 01 … 11, 12 in BCD. Bit 7 is the PM flag (1 = PM), and it toggles only on the step from 11 to 12. The step from 12 to 01 keeps the flag.
- R5: In 12-hour format, the step from 11 PM (0x91) to 12 AM (0x12) raises `day_carry`. The step from 11 AM (0x11) to 12 PM (0x92) does not.
- R6: In 24-hour format, bit 7 of `hours_q` is always 0, even after a write that sets it. Bit 6 is always 0 in both formats.
- R7: A rise of `fmt_12h` converts the stored hour one cycle later. 00 becomes 12 AM (0x12), 01–11 become the same hour AM, 12 becomes 12 PM (0x92), and 13–23 become 01–11 PM.
- R8: A fall of `fmt_12h` applies the inverse mapping one cycle later. 12 AM becomes 00, 12 PM becomes 12, 01–11 PM become 13–23, and AM hours keep their number.
- R9: With `wr_en` high, `hours_q` takes `wr_data` one cycle later. Bit 6 is cleared, bit 7 is kept only in 12-hour format, and the write overrides a tick in the same cycle and raises no carry.
- R10: A tick in the same cycle as a format change is applied after the conversion, using the new format's counting rules.
- R11: With no tick, no write and no format change, `hours_q` holds its value and `day_carry` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hour_tick | input | 1 | One-cycle request to advance the hour |
| fmt_12h | input | 1 | Format select: 0 = 24-hour, 1 = 12-hour |
| wr_en | input | 1 | Load `wr_data` into the hours register |
| wr_data | input | 8 | Hour value to load (BCD, bit 7 = PM in 12-hour format) |
| hours_q | output | 8 | Current hours register value |
| day_carry | output | 1 | One-cycle pulse when the hour wraps past midnight |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This holds for a tick, a format change, a write, and the `day_carry` pulse that goes with a midnight wrap.

The bench drives inputs on the falling edge and holds them across one rising edge. It then samples `hours_q` and `day_carry` at the next falling edge, so each check reads the value registered at that single edge.

Hold checks let several idle edges pass. They then confirm that nothing moved and that no carry pulse appeared.

// File: rtl/hour_keeper_pkg.sv
package hour_keeper_pkg;

  localparam int unsigned HOUR_W   = 8;
  localparam int unsigned BIN_W    = 5;
  localparam int unsigned BCD_W    = 6;
  localparam int unsigned PM_BIT   = HOUR_W - 1;
  localparam int unsigned HOURS_DAY = 24;
  localparam int unsigned HALF_DAY  = HOURS_DAY / 2;

  function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BCD_W-1:0] b);
    logic [BIN_W-1:0] tens;
    tens = BIN_W'(b[5:4]);
    return BIN_W'(tens * BIN_W'(10)) + BIN_W'(b[3:0]);
  endfunction

  function automatic logic [BCD_W-1:0] bin_to_bcd(input logic [BIN_W-1:0] v);
    logic [1:0] tens;
    logic [BIN_W-1:0] rest;
    if (v >= BIN_W'(20)) tens = 2'd2;
    else if (v >= BIN_W'(10)) tens = 2'd1;
    else tens = 2'd0;
    rest = v - BIN_W'(BIN_W'(tens) * BIN_W'(10));
    return {tens, rest[3:0]};
  endfunction

endpackage

// File: rtl/hour_fmt_convert.sv
module hour_fmt_convert
  import hour_keeper_pkg::*;
(
  input  logic [HOUR_W-1:0] hour_in,
  input  logic              to_12h,
  output logic [HOUR_W-1:0] hour_out
);

  logic [BIN_W-1:0] val;
  logic [BIN_W-1:0] res;
  logic             pm_out;
  logic             pm_in;

  assign pm_in = hour_in[PM_BIT];

  always_comb begin
    val    = bcd_to_bin(hour_in[BCD_W-1:0]);
    res    = val;
    pm_out = 1'b0;
    if (to_12h) begin
      pm_out = (val >= BIN_W'(HALF_DAY));
      if (val == '0)                    res = BIN_W'(HALF_DAY);
      else if (val > BIN_W'(HALF_DAY))  res = val - BIN_W'(HALF_DAY);
      else                              res = val;
    end else begin
      if (val == BIN_W'(HALF_DAY))      res = pm_in ? BIN_W'(HALF_DAY) : '0;
      else if (pm_in)                   res = val + BIN_W'(HALF_DAY);
      else                              res = val;
    end
    hour_out = {pm_out, 1'b0, bin_to_bcd(res)};
  end

endmodule

// File: rtl/hour_step.sv
module hour_step
  import hour_keeper_pkg::*;
(
  input  logic [HOUR_W-1:0] hour_in,
  input  logic              mode_12h,
  output logic [HOUR_W-1:0] hour_out,
  output logic              wrap
);

  logic [BIN_W-1:0] val;
  logic [BIN_W-1:0] nxt;
  logic             pm_in;
  logic             pm_nxt;

  assign pm_in = hour_in[PM_BIT];

  always_comb begin
    val    = bcd_to_bin(hour_in[BCD_W-1:0]);
    nxt    = val + BIN_W'(1);
    pm_nxt = 1'b0;
    wrap   = 1'b0;
    if (!mode_12h) begin
      if (val >= BIN_W'(HOURS_DAY - 1)) begin
        nxt  = '0;
        wrap = 1'b1;
      end
    end else begin
      pm_nxt = pm_in;
      if (val >= BIN_W'(HALF_DAY) || val == '0) begin
        nxt = BIN_W'(1);
      end else if (val == BIN_W'(HALF_DAY - 1)) begin
        nxt    = BIN_W'(HALF_DAY);
        pm_nxt = ~pm_in;
        wrap   = pm_in;
      end
    end
    hour_out = {pm_nxt, 1'b0, bin_to_bcd(nxt)};
  end

endmodule

// File: rtl/hour_keeper.sv
module hour_keeper
  import hour_keeper_pkg::*;
#(
  parameter logic [7:0] RESET_HOURS = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hour_tick,
  input  logic       fmt_12h,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] hours_q,
  output logic       day_carry
);

  logic              mode_q;
  logic              mode_flip;
  logic [HOUR_W-1:0] conv_val;
  logic [HOUR_W-1:0] base_val;
  logic [HOUR_W-1:0] step_val;
  logic              step_wrap;
  logic [HOUR_W-1:0] load_val;

  assign mode_flip = fmt_12h ^ mode_q;

  hour_fmt_convert u_conv (
    .hour_in  (hours_q),
    .to_12h   (fmt_12h),
    .hour_out (conv_val)
  );

  assign base_val = mode_flip ? conv_val : hours_q;

  hour_step u_step (
    .hour_in  (base_val),
    .mode_12h (fmt_12h),
    .hour_out (step_val),
    .wrap     (step_wrap)
  );

  assign load_val = {fmt_12h & wr_data[PM_BIT], 1'b0, wr_data[BCD_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      hours_q   <= RESET_HOURS;
      day_carry <= 1'b0;
    end else begin
      mode_q <= fmt_12h;
      if (wr_en) begin
        hours_q   <= load_val;
        day_carry <= 1'b0;
      end else if (hour_tick) begin
        hours_q   <= step_val;
        day_carry <= step_wrap;
      end else begin
        hours_q   <= base_val;
        day_carry <= 1'b0;
      end
    end
  end

  // R6: no PM flag while counting in 24-hour format; bit 6 never set
  p_flag_zero_24h_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (hours_q[PM_BIT] == 1'b0 && hours_q[6] == 1'b0));

  // R3 / R5: a carry pulse only follows a tick without a write
  p_carry_cause_r3: assert property (@(posedge clk) disable iff (rst)
    day_carry |-> ($past(hour_tick) && !$past(wr_en)));

  // R5: a carry always lands on midnight in the active format
  p_carry_midnight_r5: assert property (@(posedge clk) disable iff (rst)
    day_carry |-> (hours_q == (mode_q ? 8'h12 : 8'h00)));

  // R11: idle cycles keep the hour
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !hour_tick && (fmt_12h == mode_q)) |=> ($stable(hours_q) && !day_carry));

  // R9: a write lands in the next cycle
  p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (hours_q[BCD_W-1:0] == $past(wr_data[BCD_W-1:0]) && !day_carry));

  // R4: the PM flag only changes on an 11 -> 12 step or a format change or a write
  p_flag_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q && fmt_12h && !wr_en && hour_tick && hours_q[BCD_W-1:0] != 6'h11)
      |=> $stable(hours_q[PM_BIT]));

endmodule

// File: tb/hour_keeper_test.sv
module hour_keeper_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       hour_tick;
  logic       fmt_12h;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] hours_q;
  logic       day_carry;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  hour_keeper uut (
    .clk       (clk),
    .rst       (rst),
    .hour_tick (hour_tick),
    .fmt_12h   (fmt_12h),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .hours_q   (hours_q),
    .day_carry (day_carry)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] exp24(input int h);
    return to_bcd(h);
  endfunction

  function automatic logic [7:0] exp12(input int h);
    int   disp;
    logic pm;
    pm   = (h >= 12);
    disp = h % 12;
    if (disp == 0) disp = 12;
    return {pm, 7'(to_bcd(disp))};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive for one rising edge (called at a falling edge), then sample at the next falling edge
  task automatic cycle(input logic t, input logic f, input logic w, input logic [7:0] d);
    hour_tick = t;
    fmt_12h   = f;
    wr_en     = w;
    wr_data   = d;
    @(negedge clk);
    hour_tick = 1'b0;
    wr_en     = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; hour_tick = 0; fmt_12h = 0; wr_en = 0; wr_data = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 hours", hours_q, 8'h00);
    check("R1 carry", {7'd0, day_carry}, 8'h00);
  endtask

  task automatic t_count24;
    cycle(0, 0, 1, 8'h00);
    for (int i = 0; i < 24; i++) begin
      cycle(1, 0, 0, 8'h00);
      check("R2 count24", hours_q, exp24((i + 1) % 24));
      check("R3 carry24", {7'd0, day_carry}, {7'd0, i == 23});
    end
  endtask

  task automatic t_count12;
    cycle(0, 0, 1, 8'h00);
    cycle(0, 1, 0, 8'h00);
    check("R7 00 to 12AM", hours_q, 8'h12);
    for (int i = 0; i < 24; i++) begin
      cycle(1, 1, 0, 8'h00);
      check("R4 count12", hours_q, exp12((i + 1) % 24));
      check("R5 carry12", {7'd0, day_carry}, {7'd0, i == 23});
    end
  endtask

  task automatic t_convert;
    for (int n = 0; n < 24; n++) begin
      cycle(0, 0, 1, exp24(n));
      cycle(0, 1, 0, 8'h00);
      check("R7 to12", hours_q, exp12(n));
      cycle(0, 0, 0, 8'h00);
      check("R8 to24", hours_q, exp24(n));
    end
  endtask

  task automatic t_write;
    cycle(0, 0, 1, 8'h93);
    check("R6 flag masked", hours_q, 8'h13);
    cycle(1, 0, 1, 8'h07);
    check("R9 write beats tick", hours_q, 8'h07);
    check("R9 no carry", {7'd0, day_carry}, 8'h00);
    cycle(0, 1, 0, 8'h00);
    cycle(0, 1, 1, 8'h85);
    check("R9 write12 keeps flag", hours_q, 8'h85);
    cycle(0, 1, 1, 8'h45);
    check("R9 bit6 cleared", hours_q, 8'h05);
  endtask

  task automatic t_hold;
    cycle(0, 1, 1, 8'h91);
    for (int i = 0; i < 5; i++) cycle(0, 1, 0, 8'h00);
    check("R11 hold", hours_q, 8'h91);
    check("R11 no carry", {7'd0, day_carry}, 8'h00);
    cycle(1, 1, 0, 8'h00);
    check("R5 11PM to 12AM", hours_q, 8'h12);
    check("R5 carry", {7'd0, day_carry}, 8'h01);
    cycle(0, 1, 1, 8'h11);
    cycle(1, 1, 0, 8'h00);
    check("R4 11AM to 12PM", hours_q, 8'h92);
    check("R5 no carry at noon", {7'd0, day_carry}, 8'h00);
  endtask

  task automatic t_combo;
    cycle(0, 0, 1, 8'h23);
    cycle(1, 1, 0, 8'h00);
    check("R10 convert then step", hours_q, 8'h12);
    check("R10 carry", {7'd0, day_carry}, 8'h01);
    cycle(0, 1, 1, 8'h11);
    cycle(1, 0, 0, 8'h00);
    check("R10 to24 then step", hours_q, 8'h12);
    check("R10 no carry", {7'd0, day_carry}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_count24;
    t_count12;
    t_convert;
    t_write;
    t_hold;
    t_combo;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule